// File: doc/BRIEF.md
# Receive Holding Buffer with Selectable Error Reporting

This block sits between a serial receiver's shift register and a processor read port. The receiver pushes each finished character into the block, together with three error bits: parity, framing and break. The processor reads characters back in arrival order. The buffer holds three characters. With the shift register in front of it, the receive path can hold four characters before any is lost.

The error bits travel with each character. The processor sees them in one of two ways. In per-character mode it sees only the bits of the character now at the head. In accumulated mode it sees a sticky OR of the bits of every character that has been at the head since the last clear command. With accumulated mode, software can check a whole message once instead of checking every byte. The block also reports whether any character is held, whether all entries are in use, and whether a push was lost because the buffer was full. One of the first two flags drives the interrupt.

Top module: `uart_rx_holdfifo`

## Requirements
- R1: After reset the buffer is empty: ready, full, overrun and irq are 0, and all three status outputs are 0.
- R2: Characters are read in push order. `rd_data` shows the head character whenever ready is 1, and a pop moves the head on to the next character. The buffer holds three entries.
- R3: `ready` is 1 exactly when at least one character is held.
- R4: `full` is 1 exactly when all three entries are in use.
- R5: A push while full, with no pop in the same cycle, is dropped and leaves the contents unchanged. It sets `overrun`, which stays 1 until a clear command. If a set and a clear fall in the same cycle, the set wins.
- R6: A push and a pop in the same cycle are both carried out and the occupancy does not change. This also holds when the buffer is full.
- R7: A pop while empty is ignored.
- R8: With `block_mode`=0, {rd_brk, rd_fe, rd_pe} equal the break, framing and parity bits stored with the head character, and are 0 when the buffer is empty.
- R9: With `block_mode`=1, each status output is the OR of that bit over every character that was at the head in any cycle since the last clear command, including the current head.
- R10: `err_clear` empties the accumulated status and clears `overrun` from the next cycle. It removes no buffered data.
- R11: `irq` equals `full` when `irq_sel_full`=1 and equals `ready` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push a character from the receiver |
| push_data | input | 8 | Character data |
| push_pe | input | 1 | Parity error of the pushed character |
| push_fe | input | 1 | Framing error of the pushed character |
| push_brk | input | 1 | Break received with the pushed character |
| pop | input | 1 | Processor read: remove the head character |
| block_mode | input | 1 | 1 selects accumulated status, 0 selects per-character status |
| irq_sel_full | input | 1 | 1 selects full as the interrupt source, 0 selects ready |
| err_clear | input | 1 | Clear the accumulated status and the overrun flag |
| rd_data | output | 8 | Head character data |
| rd_pe | output | 1 | Reported parity error |
| rd_fe | output | 1 | Reported framing error |
| rd_brk | output | 1 | Reported break |
| ready | output | 1 | At least one character held |
| full | output | 1 | All entries in use |
| overrun | output | 1 | A push was dropped since the last clear |
| irq | output | 1 | Receive interrupt |

## Verification
Pushes, pops, clears and rejected pushes act at the clock edge where they are sampled. Their effect on ready, full, overrun, head data and accumulated status appears in the cycle right after that edge, because every output is combinational from registered state. The mode and interrupt-select inputs act on the outputs in the same cycle, with no register between them. The bench applies inputs just after the falling edge and compares the outputs 1 ns later, before the next rising edge. A cycle-level model that is updated only at the rising edge supplies the expected values, so each comparison reflects all stimulus up to the previous edge plus the current static selects.

// File: rtl/uart_rx_holdfifo.sv
module uart_rx_holdfifo #(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          push_pe,
  input  logic          push_fe,
  input  logic          push_brk,
  input  logic          pop,
  input  logic          block_mode,
  input  logic          irq_sel_full,
  input  logic          err_clear,
  output logic [DW-1:0] rd_data,
  output logic          rd_pe,
  output logic          rd_fe,
  output logic          rd_brk,
  output logic          ready,
  output logic          full,
  output logic          overrun,
  output logic          irq
);
  localparam int SW = 3;
  localparam int EW = DW + SW;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] hd, tl;
  logic [CW-1:0] cnt;
  logic [SW-1:0] acc;
  logic          ovr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  wire          nonempty = cnt != '0;
  wire          is_full  = cnt == CW'(DEPTH);
  wire          do_pop   = pop & nonempty;
  wire          do_push  = push_valid & (~is_full | do_pop);
  wire          reject   = push_valid & is_full & ~pop;
  wire [EW-1:0] head     = mem[hd];
  wire [SW-1:0] head_st  = nonempty ? head[EW-1:DW] : '0;
  wire [SW-1:0] shown    = block_mode ? (acc | head_st) : head_st;

  always_ff @(posedge clk) begin
    if (do_push) mem[tl] <= {push_brk, push_fe, push_pe, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd  <= '0;
      tl  <= '0;
      cnt <= '0;
      acc <= '0;
      ovr <= 1'b0;
    end else begin
      if (do_push) tl <= nxt(tl);
      if (do_pop)  hd <= nxt(hd);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      acc <= err_clear ? '0 : (acc | head_st);
      if (reject)         ovr <= 1'b1;
      else if (err_clear) ovr <= 1'b0;
    end
  end

  assign rd_data = head[DW-1:0];
  assign {rd_brk, rd_fe, rd_pe} = shown;
  assign ready   = nonempty;
  assign full    = is_full;
  assign overrun = ovr;
  assign irq     = irq_sel_full ? is_full : nonempty;

  p_full_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> ready);
  p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop) |=> (full && overrun));
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clear) |=> overrun);
  p_pushpop_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop && ready) |=> $stable(cnt));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && pop && !push_valid) |=> !ready);
  p_char_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_mode && !ready) |-> ({rd_brk, rd_fe, rd_pe} == 3'b000));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !(push_valid && full && !pop)) |=> (!overrun && acc == '0));
  p_clear_keeps_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !pop && !push_valid) |=> $stable(cnt));
endmodule

// File: tb/test_uart_rx_holdfifo.sv
`timescale 1ns/1ps
module test_uart_rx_holdfifo;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_pe = 0, push_fe = 0, push_brk = 0;
  logic [7:0] push_data = 0;
  logic pop = 0, block_mode = 0, irq_sel_full = 0, err_clear = 0;
  logic [7:0] rd_data;
  logic rd_pe, rd_fe, rd_brk, ready, full, overrun, irq;

  always #2 clk = ~clk;

  uart_rx_holdfifo i_uart_rx_holdfifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_pe(push_pe), .push_fe(push_fe), .push_brk(push_brk), .pop(pop),
    .block_mode(block_mode), .irq_sel_full(irq_sel_full), .err_clear(err_clear),
    .rd_data(rd_data), .rd_pe(rd_pe), .rd_fe(rd_fe), .rd_brk(rd_brk),
    .ready(ready), .full(full), .overrun(overrun), .irq(irq));

  int errors = 0, checks = 0;
  int m_cnt = 0;
  logic [10:0] m_q [3];
  logic [2:0] m_acc = 0;
  logic m_ovr = 0;
  string t_lvl = "R3", t_ovr = "R5", t_st = "R8";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic [2:0] hs, st;
    hs = (m_cnt > 0) ? m_q[0][10:8] : 3'b000;
    st = block_mode ? (m_acc | hs) : hs;
    chk(t_lvl == "R3" ? "R3" : {t_lvl, "/R3"}, 11'(ready), 11'(m_cnt > 0));
    chk(t_lvl == "R3" ? "R4" : {t_lvl, "/R4"}, 11'(full), 11'(m_cnt == 3));
    chk(t_ovr, 11'(overrun), 11'(m_ovr));
    chk("R11", 11'(irq), 11'(irq_sel_full ? (m_cnt == 3) : (m_cnt > 0)));
    chk(block_mode ? (t_st == "R10" ? "R10" : "R9") : "R8", 11'({rd_brk, rd_fe, rd_pe}), 11'(st));
    if (m_cnt > 0) chk("R2", 11'(rd_data), 11'(m_q[0][7:0]));
  endtask

  task automatic step(input logic p, input logic [10:0] d, input logic po,
                      input logic bm, input logic is, input logic cl);
    logic [2:0] hs;
    logic dpop, dpush;
    push_valid = p; {push_brk, push_fe, push_pe, push_data} = d;
    pop = po; block_mode = bm; irq_sel_full = is; err_clear = cl;
    #1 compare();
    @(posedge clk);
    hs = (m_cnt > 0) ? m_q[0][10:8] : 3'b000;
    dpop = po && m_cnt > 0;
    dpush = p && (m_cnt < 3 || dpop);
    t_lvl = "R3";
    if (dpush && dpop) t_lvl = "R6";
    if (po && m_cnt == 0 && !p) t_lvl = "R7";
    t_ovr = cl ? "R10" : "R5";
    t_st = cl ? "R10" : "R8";
    m_acc = cl ? 3'b000 : (m_acc | hs);
    if (p && m_cnt == 3 && !po) m_ovr = 1;
    else if (cl) m_ovr = 0;
    if (dpop) begin
      m_q[0] = m_q[1]; m_q[1] = m_q[2]; m_cnt--;
    end
    if (dpush) begin
      m_q[m_cnt] = d; m_cnt++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", 11'({ready, full, overrun, irq}), 11'(0));
    chk("R1", 11'({rd_brk, rd_fe, rd_pe}), 11'(0));
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // directed: fill, overrun, full push+pop, drain, empty pop
    step(1, {3'b001, 8'h11}, 0, 0, 0, 0);
    step(1, {3'b010, 8'h22}, 0, 0, 1, 0);
    step(1, {3'b100, 8'h33}, 0, 0, 1, 0);
    step(1, {3'b000, 8'h44}, 0, 0, 1, 0);
    step(1, {3'b000, 8'h55}, 1, 1, 1, 0);
    step(0, 11'h0, 0, 1, 0, 0);
    step(0, 11'h0, 1, 1, 0, 0);
    step(0, 11'h0, 0, 1, 0, 1);
    step(0, 11'h0, 1, 1, 0, 0);
    step(0, 11'h0, 1, 0, 0, 0);
    step(0, 11'h0, 1, 0, 0, 0);
    step(0, 11'h0, 1, 1, 1, 0);
    step(1, {3'b111, 8'hA5}, 0, 0, 0, 1);
    step(0, 11'h0, 0, 1, 0, 1);
    // near-exhaustive pseudo-random sweep over all input combinations
    for (int i = 0; i < 4000; i++) begin
      logic bm, is;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bm = (i / 300) % 2 == 1;
      is = (i / 170) % 2 == 1;
      step(lfsr[0], {lfsr[9:7], lfsr[15:8]}, lfsr[1] & (lfsr[2] | lfsr[6]),
           bm, is, lfsr[5:3] == 3'b101 && lfsr[11]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule